// File: doc/BRIEF.md
# Interrupt and Halt Control Unit

This unit sits beside the execution core of an 8-bit-heritage processor with a 24-bit address space. It owns the two maskable-interrupt enable flags, the selected interrupt mode and the halt state. It also latches edges on the non-maskable interrupt line. At every instruction boundary that the core reports, and on every cycle while the core is halted, it decides whether to enter an interrupt. If it does, it offers the core a service request that carries a kind code and a 24-bit target address.

In the table mode, the unit builds a table address from the 8-bit I register and the vector byte that the device supplies. It then reads a little-endian 24-bit handler address over a simple request/acknowledge memory port before it makes the offer. The halt state can also end without any service: the ON key ends it, and so does any key of a key vector when the any-key mode is on. Both work even while maskable interrupts are disabled.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After a synchronous reset both enable flags are 0, the mode is 0, and svc_req_o, mem_req_o and halted_o are 0.
- R2: ei_stb_i sets both enable flags and di_stb_i clears both. Neither strobe is an instruction boundary. An IRQ held high during EI is therefore accepted only at the next insn_done_i, which is the completion of the following instruction.
- R3: A maskable IRQ (level on irq_i) is accepted at a boundary only while enable flag 1 is set. Acceptance clears both enable flags.
- R4: A rising edge on nmi_i is latched. At the next boundary after the latch, enable flag 2 takes the value of enable flag 1, enable flag 1 is cleared, and the unit offers kind 2'b01 with address 0x000066.
- R5: When a latched NMI and an enabled IRQ are present at the same boundary, the NMI is serviced and the IRQ stays pending.
- R6: In modes 0, 1 and 3, an accepted IRQ is offered as kind 2'b10 with address 0x000038.
- R7: In mode 2, the table address is {8'h00, I, vector}. The unit reads the bytes at T, T+1 and T+2 (24-bit sums), holding mem_req_o and mem_addr_o until mem_ack_i. It then offers kind 2'b11 with the handler {byte T+2, byte T+1, byte T}.
- R8: An offer keeps svc_req_o, svc_kind_o and svc_addr_o unchanged until svc_ack_i. No new interrupt is accepted while an offer or a handler read is in progress, and mem_req_o and svc_req_o are never high together.
- R9: retn_stb_i copies enable flag 2 into enable flag 1.
- R10: halt_stb_i raises halted_o on the next cycle. While halted, every cycle is a boundary: an enabled IRQ or a latched NMI ends the halt and is serviced without insn_done_i.
- R11: While halted, on_key_i ends the halt even with enable flag 1 clear, and makes no service request.
- R12: While halted with anykey_en_i high, any set bit of keys_i ends the halt. With anykey_en_i low, keys_i has no effect.
- R13: im_stb_i loads the mode from im_sel_i. Value 2 selects the table dispatch of R7, and every other value selects the restart of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Maskable interrupt request level |
| nmi_i | input | 1 | Non-maskable interrupt line, edge-sensitive |
| on_key_i | input | 1 | ON key pressed |
| keys_i | input | NKEYS | Key matrix press vector |
| anykey_en_i | input | 1 | Let any key end the halt |
| insn_done_i | input | 1 | Instruction-completion boundary strobe |
| ei_stb_i | input | 1 | EI executed |
| di_stb_i | input | 1 | DI executed |
| retn_stb_i | input | 1 | RETN executed |
| im_stb_i | input | 1 | IM executed |
| im_sel_i | input | 2 | Mode operand of IM |
| halt_stb_i | input | 1 | HALT executed |
| i_reg_i | input | IW | I register |
| irq_vec_i | input | 8 | Vector byte from the interrupting device |
| svc_req_o | output | 1 | Service offer to the core |
| svc_kind_o | output | 2 | 01 NMI, 10 restart, 11 table handler |
| svc_addr_o | output | AW | Service target address |
| svc_ack_i | input | 1 | Core accepts the offer |
| mem_req_o | output | 1 | Handler-table read request |
| mem_addr_o | output | AW | Handler-table read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| halted_o | output | 1 | Core is halted |

## Verification
The hardest situation to reach from the ports is a set of interrupt sources competing with an offer that has not been acknowledged, or with a handler read that is stalled. The bench keeps svc_ack_i low while it raises NMI and reports a boundary. It also withholds mem_ack_i for several cycles in the middle of a table read and checks that the address holds. The mode-2 sweep uses I and vector values that include 0xFF, so the T+1 and T+2 reads carry into higher address bytes.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    typedef enum logic [1:0] {
        SK_NONE  = 2'b00,
        SK_NMI   = 2'b01,
        SK_RST   = 2'b10,
        SK_TABLE = 2'b11
    } svc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_OFFER = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic nmi;
        logic irq;
        logic wake;
    } take_t;

    localparam logic [1:0] MODE_TABLE = 2'd2;

    function automatic logic is_table_mode(input logic [1:0] m);
        return m == MODE_TABLE;
    endfunction

endpackage

// File: rtl/irqh_flags.sv
module irqh_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       ei_i,
    input  logic       di_i,
    input  logic       retn_i,
    input  logic       im_i,
    input  logic [1:0] im_sel_i,
    input  logic       nmi_acc_i,
    input  logic       irq_acc_i,
    output logic       iff1_o,
    output logic [1:0] mode_o
);
    logic iff1_q, iff2_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1_q <= 1'b0;
            iff2_q <= 1'b0;
        end else if (nmi_acc_i) begin
            iff2_q <= iff1_q;
            iff1_q <= 1'b0;
        end else if (irq_acc_i || di_i) begin
            iff1_q <= 1'b0;
            iff2_q <= 1'b0;
        end else if (ei_i) begin
            iff1_q <= 1'b1;
            iff2_q <= 1'b1;
        end else if (retn_i) begin
            iff1_q <= iff2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= 2'd0;
        else if (im_i) mode_q <= im_sel_i;
    end

    assign iff1_o = iff1_q;
    assign mode_o = mode_q;

    // R4: NMI entry saves flag 1 into flag 2 and clears flag 1
    p_nmi_save_r4: assert property (@(posedge clk) disable iff (rst)
        nmi_acc_i |=> (iff2_q == $past(iff1_q)) && !iff1_q);

    // R9: RETN restores flag 1 from flag 2
    p_retn_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (retn_i && !nmi_acc_i && !irq_acc_i && !ei_i && !di_i) |=> iff1_q == $past(iff2_q));

    // R3: acceptance leaves both flags clear
    p_irq_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_acc_i && !nmi_acc_i) |=> !iff1_q && !iff2_q);

endmodule

// File: rtl/irqh_arb.sv
module irqh_arb
    import irqh_pkg::*;
#(
    parameter int NKEYS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_i,
    input  logic             irq_i,
    input  logic             iff1_i,
    input  logic             ready_i,
    input  logic             done_i,
    input  logic             halted_i,
    input  logic             on_key_i,
    input  logic             anykey_en_i,
    input  logic [NKEYS-1:0] keys_i,
    output take_t            take_o
);
    logic nmi_prev_q, nmi_pend_q;
    logic boundary, key_wake;

    assign boundary = ready_i && (done_i || halted_i);
    assign key_wake = on_key_i || (anykey_en_i && (|keys_i));

    always_comb begin
        take_o.nmi  = boundary && nmi_pend_q;
        take_o.irq  = boundary && !nmi_pend_q && irq_i && iff1_i;
        take_o.wake = ready_i && halted_i && !take_o.nmi && !take_o.irq && key_wake;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= (nmi_i && !nmi_prev_q) || (nmi_pend_q && !take_o.nmi);
        end
    end

    // R5/R8: at most one decision per cycle
    p_one_take_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_o.nmi, take_o.irq, take_o.wake}));

endmodule

// File: rtl/irqh_fetch.sv
module irqh_fetch #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic          mem_ack_i,
    input  logic [7:0]    mem_data_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          done_o,
    output logic [AW-1:0] handler_o
);
    localparam int NB = AW / 8;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    logic          busy_q;
    logic [CW-1:0] idx_q;
    logic [AW-1:0] base_q;
    logic [7:0]    bytes_q [NB];
    logic          last;

    assign last       = idx_q == CW'(NB - 1);
    assign mem_req_o  = busy_q;
    assign mem_addr_o = base_q + AW'(idx_q);
    assign done_o     = busy_q && mem_ack_i && last;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        if (b == NB - 1) begin : g_top
            assign handler_o[b*8 +: 8] = mem_data_i;
        end else begin : g_low
            assign handler_o[b*8 +: 8] = bytes_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            base_q <= base_i;
        end else if (busy_q && mem_ack_i) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= CW'(idx_q + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (busy_q && mem_ack_i) bytes_q[idx_q] <= mem_data_i;
    end

    // R7: a stalled read keeps its request and address
    p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o));

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
    import irqh_pkg::*;
#(
    parameter int            AW       = 24,
    parameter int            IW       = 8,
    parameter int            NKEYS    = 8,
    parameter logic [AW-1:0] NMI_ADDR = 24'h000066,
    parameter logic [AW-1:0] RST_ADDR = 24'h000038
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_i,
    input  logic             nmi_i,
    input  logic             on_key_i,
    input  logic [NKEYS-1:0] keys_i,
    input  logic             anykey_en_i,
    input  logic             insn_done_i,
    input  logic             ei_stb_i,
    input  logic             di_stb_i,
    input  logic             retn_stb_i,
    input  logic             im_stb_i,
    input  logic [1:0]       im_sel_i,
    input  logic             halt_stb_i,
    input  logic [IW-1:0]    i_reg_i,
    input  logic [7:0]       irq_vec_i,
    output logic             svc_req_o,
    output logic [1:0]       svc_kind_o,
    output logic [AW-1:0]    svc_addr_o,
    input  logic             svc_ack_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [7:0]       mem_data_i,
    output logic             halted_o
);
    ctl_state_e    state_q;
    svc_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic          halted_q;
    logic          iff1;
    logic [1:0]    mode;
    take_t         take;
    logic          fetch_start, fetch_done;
    logic [AW-1:0] handler, table_base;

    assign table_base  = AW'({i_reg_i, irq_vec_i});
    assign fetch_start = take.irq && is_table_mode(mode);

    irqh_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .ei_i      (ei_stb_i),
        .di_i      (di_stb_i),
        .retn_i    (retn_stb_i),
        .im_i      (im_stb_i),
        .im_sel_i  (im_sel_i),
        .nmi_acc_i (take.nmi),
        .irq_acc_i (take.irq),
        .iff1_o    (iff1),
        .mode_o    (mode)
    );

    irqh_arb #(.NKEYS(NKEYS)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .nmi_i       (nmi_i),
        .irq_i       (irq_i),
        .iff1_i      (iff1),
        .ready_i     (state_q == ST_IDLE),
        .done_i      (insn_done_i),
        .halted_i    (halted_q),
        .on_key_i    (on_key_i),
        .anykey_en_i (anykey_en_i),
        .keys_i      (keys_i),
        .take_o      (take)
    );

    irqh_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start_i    (fetch_start),
        .base_i     (table_base),
        .mem_ack_i  (mem_ack_i),
        .mem_data_i (mem_data_i),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .done_o     (fetch_done),
        .handler_o  (handler)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= SK_NONE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take.nmi) begin
                        state_q <= ST_OFFER;
                        kind_q  <= SK_NMI;
                        addr_q  <= NMI_ADDR;
                    end else if (fetch_start) begin
                        state_q <= ST_FETCH;
                    end else if (take.irq) begin
                        state_q <= ST_OFFER;
                        kind_q  <= SK_RST;
                        addr_q  <= RST_ADDR;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        state_q <= ST_OFFER;
                        kind_q  <= SK_TABLE;
                        addr_q  <= handler;
                    end
                end
                default: begin
                    if (svc_ack_i) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   halted_q <= 1'b0;
        else if (take.nmi || take.irq || take.wake) halted_q <= 1'b0;
        else if (halt_stb_i)                        halted_q <= 1'b1;
    end

    assign svc_req_o  = state_q == ST_OFFER;
    assign svc_kind_o = kind_q;
    assign svc_addr_o = addr_q;
    assign halted_o   = halted_q;

    // R8: an offer is held steady until the core acknowledges it
    p_offer_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (svc_req_o && !svc_ack_i) |=> svc_req_o && $stable(svc_addr_o) && $stable(svc_kind_o));

    // R8: table read and offer never overlap
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_o && svc_req_o));

    // R4: an NMI offer always targets the fixed entry
    p_nmi_target_r4: assert property (@(posedge clk) disable iff (rst)
        (svc_req_o && svc_kind_o == SK_NMI) |-> svc_addr_o == NMI_ADDR);

    // R6: a restart offer always targets the fixed restart entry
    p_rst_target_r6: assert property (@(posedge clk) disable iff (rst)
        (svc_req_o && svc_kind_o == SK_RST) |-> svc_addr_o == RST_ADDR);

endmodule

// File: tb/sim_irq_halt_ctrl.sv
module sim_irq_halt_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic irq = 0, nmi = 0, on_key = 0, anykey_en = 0, insn_done = 0;
    logic ei = 0, di = 0, retn = 0, im = 0, halt = 0, svc_ack = 0, mem_ready = 0;
    logic [1:0] im_sel = 0;
    logic [7:0] keys = 0, i_reg = 0, vec = 0;
    logic svc_req, mem_req, halted;
    logic [1:0] svc_kind;
    logic [23:0] svc_addr, mem_addr;
    logic [7:0] mem_data;

    int total = 0, bad = 0;
    bit finished = 0;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'(a[23:16] + 8'h1B);
    endfunction

    assign mem_data = memf(mem_addr);

    irq_halt_ctrl u0 (
        .clk(clk), .rst(rst), .irq_i(irq), .nmi_i(nmi), .on_key_i(on_key),
        .keys_i(keys), .anykey_en_i(anykey_en), .insn_done_i(insn_done),
        .ei_stb_i(ei), .di_stb_i(di), .retn_stb_i(retn), .im_stb_i(im),
        .im_sel_i(im_sel), .halt_stb_i(halt), .i_reg_i(i_reg), .irq_vec_i(vec),
        .svc_req_o(svc_req), .svc_kind_o(svc_kind), .svc_addr_o(svc_addr),
        .svc_ack_i(svc_ack), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_ack_i(mem_ready), .mem_data_i(mem_data), .halted_o(halted)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_done(); insn_done = 1; step(1); insn_done = 0; endtask
    task automatic do_ei();   ei = 1;        step(1); ei = 0;        endtask
    task automatic do_di();   di = 1;        step(1); di = 0;        endtask
    task automatic do_retn(); retn = 1;      step(1); retn = 0;      endtask
    task automatic do_halt(); halt = 1;      step(1); halt = 0;      endtask
    task automatic do_ack();  svc_ack = 1;   step(1); svc_ack = 0;   endtask
    task automatic do_im(input logic [1:0] m);
        im = 1; im_sel = m; step(1); im = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        // R1 reset state
        chk("R1 svc_req", svc_req, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 halted", halted, 0);
        irq = 1;
        do_done();
        chk("R1 flags clear after reset, no accept", svc_req, 0);
        chk("R3 disabled irq ignored", svc_req, 0);

        // R2 EI delay, R6 restart
        do_im(2'd1);
        do_ei();
        chk("R2 no accept at EI", svc_req, 0);
        do_done();
        chk("R2 accept after next insn", svc_req, 1);
        chk("R6 kind", svc_kind, 2'b10);
        chk("R6 addr", svc_addr, 24'h38);
        do_ack();
        chk("R8 offer dropped after ack", svc_req, 0);
        do_done();
        chk("R3 accept cleared enable", svc_req, 0);
        do_ei(); do_di();
        do_done();
        chk("R2 DI clears enables", svc_req, 0);
        irq = 0;

        // R13/R6/R7 sweep over modes, I and vector values
        for (int m = 0; m < 4; m++) begin
            do_im(2'(m));
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    logic [23:0] t, h;
                    i_reg = (a == 0) ? 8'h00 : (a == 1) ? 8'h5A : 8'hFF;
                    vec   = (b == 0) ? 8'h00 : (b == 1) ? 8'h3C : 8'hFF;
                    t = {8'h00, i_reg, vec};
                    h = {memf(t + 24'd2), memf(t + 24'd1), memf(t)};
                    mem_ready = 1;
                    do_ei();
                    irq = 1;
                    do_done();
                    irq = 0;
                    if (m == 2) begin
                        chk("R7 read starts", mem_req, 1);
                        chk("R7 first address", mem_addr, t);
                        step(3);
                        chk("R7 kind", svc_kind, 2'b11);
                        chk("R7 handler", svc_addr, h);
                    end else begin
                        chk("R13 restart kind", svc_kind, 2'b10);
                        chk("R6 restart addr", svc_addr, 24'h38);
                    end
                    chk("R13 offer up", svc_req, 1);
                    do_ack();
                end
            end
        end

        // R7 stalled read
        do_im(2'd2);
        i_reg = 8'h12; vec = 8'hFE; mem_ready = 0;
        do_ei();
        irq = 1;
        do_done();
        irq = 0;
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk("R7 stall holds req", mem_req, 1);
            chk("R7 stall holds addr", mem_addr, 24'h0012FE);
            chk("R8 no offer during read", svc_req, 0);
        end
        mem_ready = 1;
        step(3);
        chk("R7 stalled handler", svc_addr,
            {memf(24'h001300), memf(24'h0012FF), memf(24'h0012FE)});
        do_ack();
        do_im(2'd1);

        // R4/R5 NMI priority, R9 RETN
        do_ei();
        nmi = 1; irq = 1;
        step(1);
        do_done();
        chk("R5 NMI wins", svc_kind, 2'b01);
        chk("R4 NMI addr", svc_addr, 24'h66);
        do_ack();
        nmi = 0;
        do_done();
        chk("R4 flag 1 cleared by NMI", svc_req, 0);
        do_retn();
        do_done();
        chk("R9 RETN restores enable", svc_req, 1);
        chk("R9 restart kind", svc_kind, 2'b10);
        do_ack();
        irq = 0;
        do_di();
        nmi = 1; step(1); do_done(); do_ack(); nmi = 0;
        do_retn();
        irq = 1;
        do_done();
        chk("R9 RETN after NMI with flag 1 clear", svc_req, 0);
        irq = 0;

        // R8 no accept while offering
        do_ei();
        irq = 1;
        do_done();
        irq = 0;
        nmi = 1; step(1);
        do_done();
        chk("R8 offer unchanged kind", svc_kind, 2'b10);
        chk("R8 offer unchanged addr", svc_addr, 24'h38);
        do_ack();
        nmi = 0;
        do_done();
        chk("R8 NMI served later", svc_kind, 2'b01);
        chk("R8 NMI offer", svc_req, 1);
        do_ack();

        // R10/R11/R12 halt and wake
        do_di();
        do_halt();
        chk("R10 halted set", halted, 1);
        irq = 1; step(2);
        chk("R10 disabled irq keeps halt", halted, 1);
        chk("R10 no service", svc_req, 0);
        on_key = 1; step(1); on_key = 0;
        chk("R11 ON key wakes", halted, 0);
        chk("R11 no service", svc_req, 0);
        irq = 0;
        do_halt();
        keys = 8'h10; anykey_en = 0; step(2);
        chk("R12 key ignored without mode", halted, 1);
        anykey_en = 1; step(1);
        chk("R12 any key wakes", halted, 0);
        keys = 0; anykey_en = 0;
        do_ei();
        do_halt();
        irq = 1; step(1);
        chk("R10 irq ends halt", halted, 0);
        chk("R10 irq served", svc_req, 1);
        do_ack();
        irq = 0;
        do_di();
        do_halt();
        nmi = 1; step(1);
        chk("R10 halt held until NMI latched", halted, 1);
        step(1);
        chk("R10 NMI ends halt", halted, 0);
        chk("R10 NMI kind", svc_kind, 2'b01);
        do_ack();
        nmi = 0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule